// File: doc/BRIEF.md
# PCI Base Address Register Set

This block holds the four base address registers of one PCI function and decodes bus addresses against them. Register 0 opens a 4 KB prefetchable memory window onto the control/status registers. Register 1 opens a 64-byte I/O window onto the same registers. Register 2 opens a 128 KB flash window, and register 3 opens a 1 MB expansion ROM window. Configuration software reaches the registers through a plain dword port. That port carries a write strobe, a two-bit register index, four byte enables and write data. Read data returns combinationally for whichever index is presented.

Software sizes each window in the usual way. It writes all ones, reads the register back, and finds the writable base bits above a fixed low-bit encoding. After software programs a base, the block compares every bus address, together with its space type, against each window. It raises one hit output per window. Memory windows also need the memory enable from the command register, and the I/O window needs the I/O enable. The flash window cannot be turned off. A boot-disable strap hides the expansion ROM completely.

Top module: `pci_bar_set`

## Requirements
- R1: After a synchronous reset every base is zero. Index 0 reads 0x00000008, index 1 reads 0x00000001, index 2 reads 0x00000000, and index 3 reads 0x00000000.
- R2: The index selects the register: 0 control/status memory, 1 control/status I/O, 2 flash, 3 expansion ROM. In the memory registers bits 2:1 read 00, and bit 0 reads 0. Bit 3 reads 1 for index 0 and 0 for index 2.
- R3: Writing 0xFFFFFFFF to index 0 with all byte enables makes it read 0xFFFFF008, because only bits 31:12 are writable.
- R4: Writing 0xFFFFFFFF to index 1 makes it read 0xFFFFFFC1. Bit 0 reads 1, bit 1 reads 0, and bits 31:6 are writable.
- R5: Writing 0xFFFFFFFF to index 2 makes it read 0xFFFE0000, because only bits 31:17 are writable.
- R6: Writing 0xFFFFFFFF to index 3 makes it read 0xFFF00001. Bits 31:20 hold the base and bit 0 is a writable decode enable. All other bits read 0.
- R7: A write changes only the byte lanes whose enable is set. Enable bit n covers data bits 8n+7:8n.
- R8: While boot_disable is high, index 3 reads 0x00000000 and rom_hit stays low, whatever has been written.
- R9: csr_mem_hit is high exactly when bus_space is 0, mem_en is high, and bus_addr[31:12] equals the programmed base. flash_hit follows the same rule over bits 31:17.
- R10: csr_io_hit is high exactly when bus_space is 1, io_en is high, and bus_addr[31:6] equals the programmed base.
- R11: rom_hit is high exactly when bus_space is 0, mem_en is high, the ROM decode-enable bit is 1, boot_disable is low, and bus_addr[31:20] equals the base.
- R12: The flash window has no disable. Writing bit 0 of index 2 has no effect, and flash_hit depends only on the rule in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Register index (0..3) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_idx |
| boot_disable | input | 1 | Strap that hides the expansion ROM register |
| mem_en | input | 1 | Command-register memory space enable |
| io_en | input | 1 | Command-register I/O space enable |
| bus_addr | input | 32 | Address being decoded |
| bus_space | input | 1 | 0 = memory cycle, 1 = I/O cycle |
| csr_mem_hit | output | 1 | Hit in control/status memory window |
| csr_io_hit | output | 1 | Hit in control/status I/O window |
| flash_hit | output | 1 | Hit in flash window |
| rom_hit | output | 1 | Hit in expansion ROM window |

## Verification
A corrupted base register shows up at the ports in the same cycle it is read: the read value changes, and so does the hit output for every address that lies near the window boundary. The bench therefore compares the read data and all four hit outputs against a reference model on every clock. A wrong writable mask shows up at once in the read-back after an all-ones write. A bad byte-lane decode shows up in the read that follows a partial write. A missing enable gate raises a hit on the first address inside a window that should be disabled.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;

    localparam int unsigned DW       = 32;
    localparam int unsigned NUM_BARS = 4;
    localparam int unsigned IDX_W    = $clog2(NUM_BARS);
    localparam int unsigned BE_W     = DW / 8;

    typedef enum logic [IDX_W-1:0] {
        BAR_CSR_MEM = 2'd0,
        BAR_CSR_IO  = 2'd1,
        BAR_FLASH   = 2'd2,
        BAR_ROM     = 2'd3
    } bar_idx_e;

    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } space_e;

    typedef struct packed {
        logic [DW-1:0] base;
        logic          en;
    } bar_view_t;

    function automatic logic [DW-1:0] size_mask(input int unsigned lg);
        return ~((DW'(1) << lg) - DW'(1));
    endfunction

    function automatic logic [DW-1:0] lane_mask(input logic [BE_W-1:0] be);
        logic [DW-1:0] m;
        for (int i = 0; i < BE_W; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    // Fixed low nibble per register: io flag, type, prefetchable
    function automatic logic [3:0] low_bits(input int unsigned idx);
        case (idx)
            0:       return 4'b1000;
            1:       return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/bar_reg.sv
module bar_reg
    import pci_bar_pkg::*;
#(
    parameter int unsigned LG     = 12,
    parameter logic [3:0]  LOW    = 4'b0000,
    parameter bit          HAS_EN = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [BE_W-1:0] be,
    input  logic [DW-1:0]   wdata,
    input  logic            hide,
    output logic [DW-1:0]   rd_val,
    output bar_view_t       view
);
    localparam logic [DW-1:0] BASE_M = size_mask(LG);
    localparam logic [DW-1:0] WMASK  = BASE_M | (HAS_EN ? DW'(1) : DW'(0));

    logic [DW-1:0] q;
    logic [DW-1:0] lm;

    assign lm = lane_mask(be);

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= ((q & ~lm) | (wdata & lm)) & WMASK;
    end

    assign rd_val    = hide ? '0 : (q | DW'(LOW));
    assign view.base = q & BASE_M;
    assign view.en   = HAS_EN ? q[0] : 1'b1;

    // R3, R4, R5, R6: all-ones write reads back mask plus fixed encoding
    a_r3_size_readback: assert property (@(posedge clk) disable iff (rst)
        (wr_en && be == '1 && wdata == '1 && !hide) |=> (hide || rd_val == (WMASK | DW'(LOW))));

    // R7: a lane without enable keeps its value
    a_r7_lane_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !be[1] && !hide) |=> (hide || rd_val[15:8] == $past(rd_val[15:8])));
endmodule

// File: rtl/bar_match.sv
module bar_match
    import pci_bar_pkg::*;
#(
    parameter int unsigned LG    = 12,
    parameter bit          IS_IO = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] addr,
    input  space_e        space,
    input  bar_view_t     view,
    input  logic          gate,
    output logic          hit
);
    localparam logic [DW-1:0] BASE_M = size_mask(LG);
    localparam space_e        MY_SP  = IS_IO ? SPACE_IO : SPACE_MEM;

    assign hit = gate && view.en && (space == MY_SP) && ((addr & BASE_M) == view.base);

    // R9, R10: no hit without the space enable and a matching space
    a_r9_hit_needs_enable: assert property (@(posedge clk) disable iff (rst)
        hit |-> (gate && space == MY_SP));
endmodule

// File: rtl/pci_bar_set.sv
module pci_bar_set
    import pci_bar_pkg::*;
#(
    parameter int unsigned CSR_MEM_LG = 12,
    parameter int unsigned CSR_IO_LG  = 6,
    parameter int unsigned FLASH_LG   = 17,
    parameter int unsigned ROM_LG     = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_idx,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        boot_disable,
    input  logic        mem_en,
    input  logic        io_en,
    input  logic [31:0] bus_addr,
    input  logic        bus_space,
    output logic        csr_mem_hit,
    output logic        csr_io_hit,
    output logic        flash_hit,
    output logic        rom_hit
);
    localparam int unsigned BAR_LG [NUM_BARS] = '{CSR_MEM_LG, CSR_IO_LG, FLASH_LG, ROM_LG};

    logic [DW-1:0]       rd_arr [NUM_BARS];
    bar_view_t           views  [NUM_BARS];
    logic [NUM_BARS-1:0] hits;
    logic [NUM_BARS-1:0] gates;
    space_e              sp;

    assign sp = space_e'(bus_space);

    assign gates[BAR_CSR_MEM] = mem_en;
    assign gates[BAR_CSR_IO]  = io_en;
    assign gates[BAR_FLASH]   = mem_en;
    assign gates[BAR_ROM]     = mem_en && !boot_disable;

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        localparam bit IS_ROM = (g == BAR_ROM);
        localparam bit IS_IO  = (g == BAR_CSR_IO);

        bar_reg #(
            .LG     (BAR_LG[g]),
            .LOW    (low_bits(g)),
            .HAS_EN (IS_ROM)
        ) u_reg (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (cfg_wr && cfg_idx == IDX_W'(g)),
            .be     (cfg_be),
            .wdata  (cfg_wdata),
            .hide   (IS_ROM && boot_disable),
            .rd_val (rd_arr[g]),
            .view   (views[g])
        );

        bar_match #(
            .LG    (BAR_LG[g]),
            .IS_IO (IS_IO)
        ) u_match (
            .clk   (clk),
            .rst   (rst),
            .addr  (bus_addr),
            .space (sp),
            .view  (views[g]),
            .gate  (gates[g]),
            .hit   (hits[g])
        );
    end

    assign cfg_rdata   = rd_arr[cfg_idx];
    assign csr_mem_hit = hits[BAR_CSR_MEM];
    assign csr_io_hit  = hits[BAR_CSR_IO];
    assign flash_hit   = hits[BAR_FLASH];
    assign rom_hit     = hits[BAR_ROM];

    // R8: strap hides the ROM register and its window
    a_r8_rom_silent: assert property (@(posedge clk) disable iff (rst)
        boot_disable |-> (!rom_hit && (cfg_idx != BAR_ROM || cfg_rdata == '0)));

    // R10: I/O window answers only I/O cycles with I/O enabled
    a_r10_io_space: assert property (@(posedge clk) disable iff (rst)
        csr_io_hit |-> (bus_space && io_en && !csr_mem_hit && !flash_hit && !rom_hit));

    // R4: I/O register bit 1 is reserved and reads zero, bit 0 reads one
    a_r4_io_low: assert property (@(posedge clk) disable iff (rst)
        (cfg_idx == BAR_CSR_IO) |-> (cfg_rdata[1:0] == 2'b01));
endmodule

// File: tb/pci_bar_set_tb.sv
`timescale 1ns/1ps
module pci_bar_set_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_idx = 2'd0;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        boot_disable = 1'b0;
    logic        mem_en = 1'b0;
    logic        io_en = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_space = 1'b0;
    logic        csr_mem_hit, csr_io_hit, flash_hit, rom_hit;

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    logic [31:0] mdl [4];

    always #2.5 clk = ~clk;

    pci_bar_set u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .boot_disable(boot_disable),
        .mem_en(mem_en), .io_en(io_en), .bus_addr(bus_addr), .bus_space(bus_space),
        .csr_mem_hit(csr_mem_hit), .csr_io_hit(csr_io_hit), .flash_hit(flash_hit),
        .rom_hit(rom_hit)
    );

    function automatic logic [31:0] wmask(input int i);
        case (i)
            0: return 32'hFFFF_F000;
            1: return 32'hFFFF_FFC0;
            2: return 32'hFFFE_0000;
            default: return 32'hFFF0_0001;
        endcase
    endfunction

    function automatic logic [31:0] fixed(input int i);
        case (i)
            0: return 32'h8;
            1: return 32'h1;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input int i);
        if (i == 3 && boot_disable) return 32'h0;
        return mdl[i] | fixed(i);
    endfunction

    function automatic logic in_win(input int i);
        logic [31:0] m;
        m = wmask(i) & 32'hFFFF_FFFE;
        return (bus_addr & m) == (mdl[i] & m);
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("rdata", cfg_rdata, exp_read(int'(cfg_idx)));
        check("csr_mem_hit", 32'(csr_mem_hit), 32'(!bus_space && mem_en && in_win(0)));
        check("csr_io_hit",  32'(csr_io_hit),  32'(bus_space && io_en && in_win(1)));
        check("flash_hit",   32'(flash_hit),   32'(!bus_space && mem_en && in_win(2)));
        check("rom_hit",     32'(rom_hit),
              32'(!bus_space && mem_en && !boot_disable && mdl[3][0] && in_win(3)));
    endtask

    // drive at negedge, compare mid-low phase, model updates at posedge
    task automatic step(input logic wr, input int idx, input logic [3:0] be, input logic [31:0] d);
        cfg_wr = wr; cfg_idx = 2'(idx); cfg_be = be; cfg_wdata = d;
        #1;
        compare_all();
        @(posedge clk);
        if (wr) begin
            logic [31:0] lm;
            for (int b = 0; b < 4; b++) lm[b*8 +: 8] = {8{be[b]}};
            mdl[idx] = ((mdl[idx] & ~lm) | (d & lm)) & wmask(idx);
        end
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int idx); step(1'b0, idx, 4'h0, 32'h0); endtask
    task automatic wr(input int idx, input logic [3:0] be, input logic [31:0] d);
        step(1'b1, idx, be, d);
    endtask
    task automatic probe(input logic [31:0] a, input logic sp);
        bus_addr = a; bus_space = sp; rd(0);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1, R2: reset values and fixed encodings per index
        cur_req = "R1";
        for (int i = 0; i < 4; i++) rd(i);
        cur_req = "R2";
        for (int i = 0; i < 4; i++) rd(i);
        // sizing
        cur_req = "R3"; wr(0, 4'hF, 32'hFFFF_FFFF); rd(0);
        cur_req = "R4"; wr(1, 4'hF, 32'hFFFF_FFFF); rd(1);
        cur_req = "R5"; wr(2, 4'hF, 32'hFFFF_FFFF); rd(2);
        cur_req = "R6"; wr(3, 4'hF, 32'hFFFF_FFFF); rd(3);
        // program bases
        cur_req = "R2";
        wr(0, 4'hF, 32'h1234_5678); rd(0);
        wr(1, 4'hF, 32'h0000_C0FF); rd(1);
        wr(2, 4'hF, 32'hA5A5_FFFF); rd(2);
        wr(3, 4'hF, 32'h7760_0000); rd(3);
        // R7: partial lane writes
        cur_req = "R7";
        wr(0, 4'b0100, 32'hFFAB_FFFF); rd(0);
        wr(1, 4'b0001, 32'h0000_00F3); rd(1);
        wr(2, 4'b1000, 32'h3CFF_FFFF); rd(2);
        // R12: flash bit 0 write ignored
        cur_req = "R12";
        wr(2, 4'h1, 32'h0000_0001); rd(2);
        // R9: memory hits
        cur_req = "R9";
        mem_en = 1'b0; probe(32'h12AB_5000, 1'b0);
        mem_en = 1'b1;
        probe(32'h12AB_5000, 1'b0); probe(32'h12AB_5FFF, 1'b0);
        probe(32'h12AB_6000, 1'b0); probe(32'h12AB_4FFF, 1'b0);
        probe(32'h12AB_5000, 1'b1);
        probe(32'h3CA4_0000, 1'b0); probe(32'h3CA5_FFFF, 1'b0); probe(32'h3CA6_0000, 1'b0);
        // R10: I/O hits
        cur_req = "R10";
        io_en = 1'b0; probe(32'h0000_C0C0, 1'b1);
        io_en = 1'b1;
        probe(32'h0000_C0C0, 1'b1); probe(32'h0000_C0FF, 1'b1);
        probe(32'h0000_C100, 1'b1); probe(32'h0000_C0C0, 1'b0);
        // R11: ROM enable bit gating
        cur_req = "R11";
        probe(32'h7765_4321, 1'b0);
        wr(3, 4'h1, 32'h0000_0001); rd(3);
        probe(32'h7765_4321, 1'b0); probe(32'h7780_0000, 1'b0);
        mem_en = 1'b0; probe(32'h7765_4321, 1'b0); mem_en = 1'b1;
        // R8: boot disable hides ROM
        cur_req = "R8";
        boot_disable = 1'b1;
        rd(3); probe(32'h7765_4321, 1'b0);
        wr(3, 4'hF, 32'hFFFF_FFFF); rd(3);
        boot_disable = 1'b0;
        rd(3); probe(32'hFFF0_0000, 1'b0);
        // R12: flash claims regardless of other state
        cur_req = "R12";
        io_en = 1'b0; probe(32'h3CA4_1234, 1'b0);
        // R1: reset again clears all
        cur_req = "R1";
        rst = 1'b1; @(posedge clk);
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) rd(i);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule